// File: doc/BRIEF.md
# Indirect Entry Table Access Window

This block gives a host processor a small register window onto an internal table of wide lookup entries. Each entry is wider than the host data bus, so the host never addresses the table directly. It moves an entry through a set of three staging words. To read entry `n`, the host writes `n` to the table-control register, waits for the fetch to land, and then reads the three staging words. To write entry `n`, it fills the three staging words and then writes `n` to the table-control register with the commit bit (bit 31) set.

The staging words are ordered with the most significant part of the entry first. Word 0 carries the entry's top bits, and word 2 carries bits 31:0. A global control register holds a table-enable level and two self-clearing actions. The clear action wipes the whole table to the free state, one entry per cycle, and shows a busy flag while it runs. The ageout action sends a one-cycle pulse to the neighbouring ageing logic. A read-only status register reports the table size in units of 1024 entries. A code of zero in that field means the small 64-entry table.

Top module: `lkup_tbl_port`

## Requirements
- R1: After reset, the control, table-control and all three staging registers read zero, and `tbl_enable`, `age_pulse` and `clr_busy` are low.
- R2: The status register at offset 0x04 returns the table-size code in bits 4:0 (entries/1024, or 0 for the 64-entry default) and zero in bits 31:5.
- R3: A write to table-control (offset 0x20) with bit 31 set and an in-range index in bits 30:0 stores the three staging words into that entry.
- R4: A write to table-control with bit 31 clear fetches the entry at the index into the staging words. The staging words are readable from the second cycle after that write, and entries keep their values across later accesses.
- R5: The staging word at 0x34 maps to entry bits 71:64 in its bits 7:0, the word at 0x38 maps to bits 63:32, and the word at 0x3C maps to bits 31:0. Bits 31:8 of the word at 0x34 always read zero, even after a write of ones.
- R6: An index at or above the table depth leaves every entry unchanged on a commit and loads all-zero staging words on a fetch. Large indices do not alias onto low entries.
- R7: Control bit 31 (offset 0x08) is a read/write enable level that drives `tbl_enable` from the cycle after the write.
- R8: Writing 1 to control bit 29 raises `age_pulse` for exactly one cycle, starting the cycle after the write. The bit always reads back as 0.
- R9: Writing 1 to control bit 30 sets every entry to zero (free type in bits 61:60) over DEPTH consecutive cycles. `clr_busy` and control bit 30 read 1 for exactly those cycles, and a commit issued while busy is ignored.
- R10: Read data is registered. It updates on the clock edge that samples `bus_rd` and holds otherwise. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tbl_enable | output | 1 | Table enable level from control bit 31 |
| age_pulse | output | 1 | One-cycle ageout request |
| clr_busy | output | 1 | High while the table clear is running |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are each held for exactly one cycle per access. They also assume that no two ageout requests are written back to back, so a pulse always traces to a single preceding write. They take reset as the only way state changes apart from bus writes and the clear sweep. The stimulus drives every access through single-cycle write and read tasks on the falling edge. It leaves an idle cycle after each fetch, and it issues a commit during a clear only after the sweep has passed that index.

// File: rtl/lkup_pkg.sv
package lkup_pkg;
  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_TCTL   = 8'h20;
  localparam logic [7:0] OFS_DATA0  = 8'h34;
  localparam logic [7:0] OFS_DATA1  = 8'h38;
  localparam logic [7:0] OFS_DATA2  = 8'h3C;

  localparam int COMMIT_BIT = 31;
  localparam int EN_BIT     = 31;
  localparam int CLR_BIT    = 30;
  localparam int AGE_BIT    = 29;
  localparam int SIZE_W     = 5;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_CTRL, SEL_TCTL, SEL_D0, SEL_D1, SEL_D2
  } reg_sel_e;

  // entries reported in units of 1024; small tables report 0
  function automatic logic [SIZE_W-1:0] size_code(input int depth);
    if (depth >= 1024) return SIZE_W'(depth / 1024);
    return '0;
  endfunction
endpackage

// File: rtl/lkup_regdec.sv
module lkup_regdec
  import lkup_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if      (addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else if (addr == ADDR_W'(OFS_CTRL))   sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFS_TCTL))   sel = SEL_TCTL;
    else if (addr == ADDR_W'(OFS_DATA0))  sel = SEL_D0;
    else if (addr == ADDR_W'(OFS_DATA1))  sel = SEL_D1;
    else if (addr == ADDR_W'(OFS_DATA2))  sel = SEL_D2;
    else                                  sel = SEL_NONE;
  end
endmodule

// File: rtl/lkup_ram.sv
module lkup_ram #(
  parameter int WIDTH = 72,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lkup_clr_seq.sv
module lkup_clr_seq #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      if (ptr == LAST) busy <= 1'b0;
      else             ptr  <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/lkup_tbl_port.sv
module lkup_tbl_port
  import lkup_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ENTRY_W = 72,
  parameter int DEPTH   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tbl_enable,
  output logic              age_pulse,
  output logic              clr_busy
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int HI_W  = ENTRY_W - 2 * DATA_W;
  localparam logic [DATA_W-2:0] DEPTH_V = (DATA_W-1)'(DEPTH);
  localparam logic [SIZE_W-1:0] SIZE_C  = size_code(DEPTH);

  reg_sel_e sel;
  lkup_regdec #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  logic wr_ctrl, wr_tctl;
  assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
  assign wr_tctl = bus_wr && (sel == SEL_TCTL);

  logic [DATA_W-2:0] req_idx;
  logic              idx_ok, commit_req;
  assign req_idx    = bus_wdata[DATA_W-2:0];
  assign idx_ok     = req_idx < DEPTH_V;
  assign commit_req = bus_wdata[COMMIT_BIT];

  // staging words, most significant entry part in word 0
  logic [HI_W-1:0]   stg_hi;
  logic [DATA_W-1:0] stg_mid, stg_lo;
  logic [DATA_W-2:0] idx_q;
  logic              en_q, age_q, ld_pend, ld_zero;

  // clear sweep
  logic [IDX_W-1:0] clr_ptr;
  lkup_clr_seq #(.DEPTH(DEPTH)) u_clr (
    .clk(clk), .rst(rst),
    .start(wr_ctrl && bus_wdata[CLR_BIT]),
    .busy(clr_busy), .ptr(clr_ptr)
  );

  // table storage with one write port shared by host and sweep
  logic               ram_we, ram_re;
  logic [IDX_W-1:0]   ram_waddr;
  logic [ENTRY_W-1:0] ram_wdata, ram_q;

  assign ram_re    = wr_tctl && !commit_req;
  assign ram_we    = clr_busy || (wr_tctl && commit_req && idx_ok);
  assign ram_waddr = clr_busy ? clr_ptr : req_idx[IDX_W-1:0];
  assign ram_wdata = clr_busy ? '0 : {stg_hi, stg_mid, stg_lo};

  lkup_ram #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(req_idx[IDX_W-1:0]), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      age_q   <= 1'b0;
      idx_q   <= '0;
      ld_pend <= 1'b0;
      ld_zero <= 1'b0;
    end else begin
      age_q   <= wr_ctrl && bus_wdata[AGE_BIT];
      ld_pend <= ram_re;
      if (ram_re) ld_zero <= !idx_ok;
      if (wr_ctrl) en_q  <= bus_wdata[EN_BIT];
      if (wr_tctl) idx_q <= req_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_hi  <= '0;
      stg_mid <= '0;
      stg_lo  <= '0;
    end else if (ld_pend) begin
      {stg_hi, stg_mid, stg_lo} <= ld_zero ? '0 : ram_q;
    end else if (bus_wr) begin
      case (sel)
        SEL_D0:  stg_hi  <= bus_wdata[HI_W-1:0];
        SEL_D1:  stg_mid <= bus_wdata;
        SEL_D2:  stg_lo  <= bus_wdata;
        default: ;
      endcase
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STATUS: rd_mux[SIZE_W-1:0] = SIZE_C;
      SEL_CTRL: begin
        rd_mux[EN_BIT]  = en_q;
        rd_mux[CLR_BIT] = clr_busy;
      end
      SEL_TCTL:   rd_mux[DATA_W-2:0] = idx_q;
      SEL_D0:     rd_mux[HI_W-1:0]   = stg_hi;
      SEL_D1:     rd_mux = stg_mid;
      SEL_D2:     rd_mux = stg_lo;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign tbl_enable = en_q;
  assign age_pulse  = age_q;
endmodule

// File: rtl/lkup_tbl_port_chk.sv
module lkup_tbl_port_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tbl_enable,
  input logic              age_pulse,
  input logic              clr_busy
);
  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(8'h04)) |=> (bus_rdata[DATA_W-1:5] == '0)); // R2

  AST_WORD0_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(8'h34)) |=> (bus_rdata[DATA_W-1:8] == '0)); // R5

  AST_ENABLE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(tbl_enable)); // R7

  AST_AGE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    age_pulse |-> $past(bus_wr)); // R8

  AST_AGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    age_pulse |=> !age_pulse); // R8

  AST_CLEAR_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(clr_busy) |-> $past(bus_wr)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

bind lkup_tbl_port lkup_tbl_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .tbl_enable(tbl_enable), .age_pulse(age_pulse),
  .clr_busy(clr_busy)
);

// File: tb/test_lkup_tbl_port.sv
module test_lkup_tbl_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int NVEC       = 6;

  // {index, word0 (bits 71:64), word1 (63:32), word2 (31:0)}
  localparam logic [77:0] VECS [NVEC] = '{
    {6'd0,  8'hA5, 32'h12345678, 32'h9ABCDEF0},
    {6'd63, 8'hFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {6'd1,  8'h01, 32'h30000000, 32'h00000001},
    {6'd17, 8'h80, 32'h00000000, 32'h80000000},
    {6'd42, 8'h3C, 32'hDEADBEEF, 32'h0F0F0F0F},
    {6'd5,  8'h00, 32'h00000001, 32'hFFFFFFFE}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tbl_enable, age_pulse, clr_busy;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lkup_tbl_port i_lkup_tbl_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tbl_enable(tbl_enable), .age_pulse(age_pulse), .clr_busy(clr_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic fetch(input logic [31:0] idx);
    wr(8'h20, idx & 32'h7FFFFFFF);
    @(posedge clk); #1;
  endtask

  task automatic stage_commit(input logic [31:0] idx, input logic [31:0] w0,
                              input logic [31:0] w1, input logic [31:0] w2);
    wr(8'h34, w0);
    wr(8'h38, w1);
    wr(8'h3C, w2);
    wr(8'h20, idx | 32'h80000000);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 enable", {31'd0, tbl_enable}, 32'd0);
    chk("R1 age", {31'd0, age_pulse}, 32'd0);
    chk("R1 busy", {31'd0, clr_busy}, 32'd0);
    rd(8'h08, v); chk("R1 ctrl", v, 32'd0);
    rd(8'h20, v); chk("R1 tctl", v, 32'd0);
    rd(8'h34, v); chk("R1 d0", v, 32'd0);
    rd(8'h38, v); chk("R1 d1", v, 32'd0);
    rd(8'h3C, v); chk("R1 d2", v, 32'd0);
    // R2 size code for 64 entries is zero
    rd(8'h04, v); chk("R2 status", v, 32'd0);
    // R10 unmapped offset
    rd(8'h10, v); chk("R10 unmapped", v, 32'd0);

    // R3 / R4 vector table: commit all, then fetch all back
    for (int i = 0; i < NVEC; i++)
      stage_commit({26'd0, VECS[i][77:72]}, {24'd0, VECS[i][71:64]},
                   VECS[i][63:32], VECS[i][31:0]);
    for (int i = 0; i < NVEC; i++) begin
      fetch({26'd0, VECS[i][77:72]});
      rd(8'h34, v); chk("R5 word0 top bits", v, {24'd0, VECS[i][71:64]});
      rd(8'h38, v); chk("R4 word1", v, VECS[i][63:32]);
      rd(8'h3C, v); chk("R3 word2", v, VECS[i][31:0]);
    end
    rd(8'h20, v); chk("R4 tctl readback", v, 32'd5);

    // R5 upper bits of word 0 read as zero
    wr(8'h34, 32'hFFFFFF5A);
    rd(8'h34, v); chk("R5 word0 upper", v, 32'h0000005A);

    // R6 out-of-range commit ignored, fetch yields zeros, no aliasing
    stage_commit(32'd64, 32'h11, 32'h22222222, 32'h33333333);
    fetch(32'd64);
    rd(8'h34, v); chk("R6 oor d0", v, 32'd0);
    rd(8'h38, v); chk("R6 oor d1", v, 32'd0);
    rd(8'h3C, v); chk("R6 oor d2", v, 32'd0);
    fetch(32'd0);
    rd(8'h38, v); chk("R6 no alias", v, 32'h12345678);
    fetch(32'h7FFFFFFF);
    rd(8'h3C, v); chk("R6 max index", v, 32'd0);

    // R7 enable level
    wr(8'h08, 32'h80000000);
    chk("R7 enable out", {31'd0, tbl_enable}, 32'd1);
    rd(8'h08, v); chk("R7 enable read", v, 32'h80000000);

    // R8 ageout pulse
    wr(8'h08, 32'hA0000000);
    chk("R8 pulse high", {31'd0, age_pulse}, 32'd1);
    @(posedge clk); #1;
    chk("R8 pulse low", {31'd0, age_pulse}, 32'd0);
    rd(8'h08, v); chk("R8 bit reads 0", v, 32'h80000000);

    // R9 clear sweep length and result
    wr(8'h08, 32'hC0000000);
    cnt = 0;
    while (clr_busy && cnt < 1000) begin
      @(posedge clk); #1;
      cnt++;
    end
    chk("R9 busy cycles", cnt, DEPTH);
    fetch(32'd63);
    rd(8'h34, v); chk("R9 cleared d0", v, 32'd0);
    rd(8'h38, v); chk("R9 cleared d1", v, 32'd0);
    fetch(32'd42);
    rd(8'h3C, v); chk("R9 cleared d2", v, 32'd0);

    // R9 commit during busy ignored; busy visible in control
    wr(8'h34, 32'h77); wr(8'h38, 32'h88888888); wr(8'h3C, 32'h99999999);
    wr(8'h08, 32'h40000000);
    rd(8'h08, v); chk("R9 busy bit", v, 32'h40000000);
    wr(8'h20, 32'h80000000);
    cnt = 0;
    while (clr_busy && cnt < 1000) begin
      @(posedge clk); #1;
      cnt++;
    end
    fetch(32'd0);
    rd(8'h38, v); chk("R9 commit while busy", v, 32'd0);
    rd(8'h08, v); chk("R9 busy done", v, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule